// File: doc/BRIEF.md
# Card Clock Stall Controller

This block decides when the card-side clock of an SD/MMC-style host must pause so that the data FIFO never runs dry while sending and never overflows while receiving. It watches three things: the FIFO occupancy, the transfer direction, and a count of the words the host still has to place in the FIFO for the current transfer. From these it drives a clock enable for the card domain. Whenever the enable is low, every state machine in the card domain holds still. The host side of the FIFO is not gated, so software or a DMA engine can refill or drain the FIFO during a pause.

Stalling is governed by a control bit that reset clears. The pause decision and the resume decision are both taken only at a card-clock cycle boundary, which is marked by a tick input, so a pause never cuts a clock pulse short. The resume points are asymmetric. A paused send resumes once the FIFO is at least half full, or once the host has stored every word of the transfer. A paused receive resumes once at least half of the FIFO is free. While the control bit is clear, the block never pauses. In that mode it records a starved send as an underrun flag and a full receive as an overrun flag. Both flags are sticky.

Top module: `cclk_flow_ctl`

## Requirements
- R1: After reset, the control bit reads 0, the clock enable is 1, the stall bit is 0, both error flags are 0 and the words-left count is 0.
- R2: With the control bit set and the clock running, a tick carrying a card request in send direction (dir_rx=0) while the occupancy is 0 drops the clock enable, and sets the stall bit, in the next cycle. Any other occupancy keeps the clock running.
- R3: While paused in send direction, a tick resumes the clock in the next cycle if the occupancy is at least DEPTH/2, or if the words-left count is 0. Otherwise the pause holds.
- R4: With the control bit set and the clock running, a tick carrying a card request in receive direction (dir_rx=1) while the occupancy equals DEPTH pauses the clock in the next cycle.
- R5: While paused in receive direction, a tick resumes the clock in the next cycle if the free space (DEPTH minus occupancy) is at least DEPTH/2. Otherwise the pause holds.
- R6: The clock enable changes only in the cycle after a tick. In a cycle without a tick, occupancy and requests have no effect on it.
- R7: With the control bit clear, a tick carrying a card request with the clock running sets the underrun flag if the direction is send and the occupancy is 0. It sets the overrun flag if the direction is receive and the occupancy is DEPTH. With the control bit set, neither flag can be set.
- R8: Writing 1 to err_clr[0] clears the underrun flag, and writing 1 to err_clr[1] clears the overrun flag. A set event in the same cycle wins over the clear.
- R9: xfer_start loads the words-left count from xfer_len. Otherwise, each host_push lowers the count by one, and the count stops at 0. A start in the same cycle as a push takes the loaded value.
- R10: Clearing the control bit while paused restores the clock enable at the next tick. With the control bit clear, the clock enable stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Write strobe for the control bit |
| cfg_fc | input | 1 | Value to write to the control bit |
| dir_rx | input | 1 | Transfer direction: 0 send, 1 receive |
| xfer_start | input | 1 | Load the words-left count |
| xfer_len | input | LEN_W | Transfer length in words |
| host_push | input | 1 | Host stored one word in the FIFO |
| fifo_level | input | LVL_W | Live FIFO occupancy, 0 to DEPTH |
| card_tick | input | 1 | Card-clock cycle boundary |
| card_req | input | 1 | Card engine needs a word moved this card cycle |
| err_clr | input | 2 | Write-one-to-clear: bit 0 underrun, bit 1 overrun |
| fc_on | output | 1 | Control bit |
| cclk_en | output | 1 | Card clock enable |
| stalled | output | 1 | Card clock is paused |
| underrun_err | output | 1 | Sticky send underrun flag |
| overrun_err | output | 1 | Sticky receive overrun flag |
| words_left | output | LEN_W | Words the host still has to store |

## Verification
The bench sweeps every pair of occupancies, from 0 to DEPTH, for the pause attempt and the resume attempt, in both directions. It runs the sweep once with host words outstanding and once with none. The sweep exposes a resume threshold that is off by one entry, a receive threshold measured against fill instead of free space, and a send stall that ignores the last-data rule and so deadlocks at the end of a transfer. Cycles without a tick, but with pause-worthy occupancy, catch a design that gates the clock mid-pulse. The error cases include a set and a clear in the same cycle, and a request while flow control is on, which would wrongly raise a flag in a design that does not block it.

// File: rtl/cclk_flow_pkg.sv
package cclk_flow_pkg;

  // Card request cannot be served by the FIFO.
  function automatic logic fifo_blocks(input logic rx, input int lvl, input int depth);
    return rx ? (lvl >= depth) : (lvl == 0);
  endfunction

  // Paused transfer may continue.
  function automatic logic fifo_recovers(input logic rx, input int lvl, input int depth,
                                         input logic all_stored);
    if (rx) return (depth - lvl) >= (depth / 2);
    return (lvl >= depth / 2) || all_stored;
  endfunction

endpackage

// File: rtl/xfer_left_cnt.sv
module xfer_left_cnt #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic             push,
  output logic [LEN_W-1:0] left,
  output logic             all_stored
);
  logic dec_evt;
  assign dec_evt    = push && !start && (left != '0);
  assign all_stored = (left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left <= '0;
    else if (start)   left <= len;
    else if (dec_evt) left <= left - 1'b1;
  end

  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (left == $past(len)));
  p_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && left == '0) |=> (left == '0));
endmodule

// File: rtl/cclk_stall_fsm.sv
module cclk_stall_fsm
  import cclk_flow_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fc_on,
  input  logic             dir_rx,
  input  logic [LVL_W-1:0] level,
  input  logic             all_stored,
  input  logic             card_tick,
  input  logic             card_req,
  output logic             cclk_en
);
  logic stall_evt, resume_evt, release_evt;

  assign stall_evt   = fc_on && cclk_en && card_tick && card_req &&
                       fifo_blocks(dir_rx, int'(level), DEPTH);
  assign resume_evt  = fc_on && !cclk_en && card_tick &&
                       fifo_recovers(dir_rx, int'(level), DEPTH, all_stored);
  assign release_evt = !fc_on && !cclk_en && card_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cclk_en <= 1'b1;
    else if (stall_evt)                 cclk_en <= 1'b0;
    else if (resume_evt || release_evt) cclk_en <= 1'b1;
  end

  p_tick_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cclk_en != $past(cclk_en)) |-> $past(card_tick));
  p_tx_pause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_on && cclk_en && card_tick && card_req && !dir_rx && level == '0) |=> !cclk_en);
  p_rx_pause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_on && cclk_en && card_tick && card_req && dir_rx && int'(level) == DEPTH) |=> !cclk_en);
  p_rx_resume_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_on && !cclk_en && card_tick && dir_rx && 2 * int'(level) <= DEPTH) |=> cclk_en);
  p_off_runs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!fc_on && card_tick) |=> cclk_en);
endmodule

// File: rtl/xfer_err_flags.sv
module xfer_err_flags #(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fc_on,
  input  logic             dir_rx,
  input  logic [LVL_W-1:0] level,
  input  logic             card_tick,
  input  logic             card_req,
  input  logic             cclk_en,
  input  logic [1:0]       err_clr,
  output logic             underrun_err,
  output logic             overrun_err
);
  logic served, under_evt, over_evt;

  assign served    = !fc_on && cclk_en && card_tick && card_req;
  assign under_evt = served && !dir_rx && (level == '0);
  assign over_evt  = served && dir_rx && (int'(level) >= DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      underrun_err <= 1'b0;
      overrun_err  <= 1'b0;
    end else begin
      if (under_evt)       underrun_err <= 1'b1;
      else if (err_clr[0]) underrun_err <= 1'b0;
      if (over_evt)        overrun_err  <= 1'b1;
      else if (err_clr[1]) overrun_err  <= 1'b0;
    end
  end

  p_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fc_on |=> !($rose(underrun_err) || $rose(overrun_err)));
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fc_on && card_tick && card_req && cclk_en && !dir_rx && level == '0) |=> underrun_err);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr[1] && !card_req) |=> !overrun_err);
endmodule

// File: rtl/cclk_flow_ctl.sv
module cclk_flow_ctl #(
  parameter int DEPTH = 8,
  parameter int LEN_W = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_fc,
  input  logic             dir_rx,
  input  logic             xfer_start,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic             host_push,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             card_tick,
  input  logic             card_req,
  input  logic [1:0]       err_clr,
  output logic             fc_on,
  output logic             cclk_en,
  output logic             stalled,
  output logic             underrun_err,
  output logic             overrun_err,
  output logic [LEN_W-1:0] words_left
);
  logic all_stored;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fc_on <= 1'b0;
    else if (cfg_we) fc_on <= cfg_fc;
  end

  assign stalled = !cclk_en;

  xfer_left_cnt #(.LEN_W(LEN_W)) u_left (
    .clk(clk), .rst_n(rst_n), .start(xfer_start), .len(xfer_len),
    .push(host_push), .left(words_left), .all_stored(all_stored)
  );

  cclk_stall_fsm #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .fc_on(fc_on), .dir_rx(dir_rx),
    .level(fifo_level), .all_stored(all_stored), .card_tick(card_tick),
    .card_req(card_req), .cclk_en(cclk_en)
  );

  xfer_err_flags #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_err (
    .clk(clk), .rst_n(rst_n), .fc_on(fc_on), .dir_rx(dir_rx),
    .level(fifo_level), .card_tick(card_tick), .card_req(card_req),
    .cclk_en(cclk_en), .err_clr(err_clr), .underrun_err(underrun_err),
    .overrun_err(overrun_err)
  );

  p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!fc_on && cclk_en && !underrun_err && !overrun_err));
endmodule

// File: tb/sim_cclk_flow_ctl.sv
`timescale 1ns/1ps
module sim_cclk_flow_ctl;
  localparam int D  = 8;
  localparam int LW = 8;
  localparam int VW = $clog2(D + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_fc = 0, dir_rx = 0, xfer_start = 0, host_push = 0;
  logic card_tick = 0, card_req = 0;
  logic [LW-1:0] xfer_len = '0;
  logic [VW-1:0] fifo_level = '0;
  logic [1:0] err_clr = '0;
  logic fc_on, cclk_en, stalled, underrun_err, overrun_err;
  logic [LW-1:0] words_left;

  int tests = 0, fails = 0;
  bit done = 0;
  logic m_fc = 0, m_en = 1, m_un = 0, m_ov = 0;
  int m_left = 0;

  always #2.5 clk = ~clk;

  cclk_flow_ctl #(.DEPTH(D), .LEN_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_fc(cfg_fc), .dir_rx(dir_rx),
    .xfer_start(xfer_start), .xfer_len(xfer_len), .host_push(host_push),
    .fifo_level(fifo_level), .card_tick(card_tick), .card_req(card_req),
    .err_clr(err_clr), .fc_on(fc_on), .cclk_en(cclk_en), .stalled(stalled),
    .underrun_err(underrun_err), .overrun_err(overrun_err), .words_left(words_left)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // one host cycle: drive at negedge, model, sample at following negedge
  task automatic step(input logic tk, input logic rq, input int lvl,
                      input logic ps = 0, input logic st = 0, input int ln = 0,
                      input logic [1:0] clr = 2'b00, input logic we = 0,
                      input logic wv = 0);
    logic n_en, n_un, n_ov, served;
    string tag;
    card_tick = tk; card_req = rq; fifo_level = VW'(lvl);
    host_push = ps; xfer_start = st; xfer_len = LW'(ln);
    err_clr = clr; cfg_we = we; cfg_fc = wv;
    n_en = m_en;
    if (!tk)       tag = "R6";
    else if (!m_fc) tag = "R10";
    else if (dir_rx) tag = m_en ? "R4" : "R5";
    else           tag = m_en ? "R2" : "R3";
    if (tk) begin
      if (!m_fc) n_en = 1;
      else if (m_en) begin
        if (rq && (dir_rx ? lvl == D : lvl == 0)) n_en = 0;
      end else begin
        if (dir_rx ? (lvl <= D - D / 2) : (lvl >= D / 2 || m_left == 0)) n_en = 1;
      end
    end
    served = tk && rq && !m_fc && m_en;
    n_un = (served && !dir_rx && lvl == 0) ? 1'b1 : (clr[0] ? 1'b0 : m_un);
    n_ov = (served && dir_rx && lvl == D) ? 1'b1 : (clr[1] ? 1'b0 : m_ov);
    if (st) m_left = ln;
    else if (ps && m_left > 0) m_left--;
    if (we) m_fc = wv;
    m_en = n_en; m_un = n_un; m_ov = n_ov;
    @(posedge clk); @(negedge clk);
    check(tag, int'(cclk_en), int'(m_en));
    check(tag, int'(stalled), int'(!m_en));
    check((n_un || m_un !== underrun_err) ? "R7/R8 underrun" : "R8 underrun",
          int'(underrun_err), int'(m_un));
    check("R7/R8 overrun", int'(overrun_err), int'(m_ov));
    check("R9", int'(words_left), m_left);
    check("R1 fc_on", int'(fc_on), int'(m_fc));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 en", int'(cclk_en), 1);
    check("R1 un", int'(underrun_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 fc_on", int'(fc_on), 0);
    check("R1 stalled", int'(stalled), 0);
    check("R1 left", int'(words_left), 0);
    check("R1 ov", int'(overrun_err), 0);

    step(0, 0, 0, 0, 0, 0, 2'b00, 1, 1);          // enable control bit
    for (int r = 0; r < 2; r++) begin
      dir_rx = r[0];
      for (int m = 0; m < 2; m++) begin
        step(0, 0, 0, 0, 1, 2);                   // R9 load
        if (m == 1) begin
          step(0, 0, 0, 1); step(0, 0, 0, 1); step(0, 0, 0, 1); // R9 floor
        end
        for (int a = 0; a <= D; a++)
          for (int b = 0; b <= D; b++) begin
            step(1, 1, a);                        // pause attempt
            step(0, 1, b);                        // no tick: R6
            step(1, 0, b);                        // resume attempt
            step(1, 0, r ? 0 : D);                // recover
          end
      end
    end
    step(0, 0, 0, 1, 1, 5);                       // R9 start beats push

    // errors with control bit off
    dir_rx = 0;
    step(0, 0, 0, 0, 0, 0, 2'b00, 1, 0);
    step(1, 1, 0);                                // R7 underrun
    step(1, 1, 0, 0, 0, 0, 2'b01);                // R8 set wins
    step(0, 0, 3, 0, 0, 0, 2'b01);                // R8 clear
    dir_rx = 1;
    step(1, 1, D - 1);                            // no overrun
    step(1, 1, D);                                // R7 overrun
    step(0, 0, 0, 0, 0, 0, 2'b10);                // R8 clear
    step(0, 1, D);                                // no tick, no flag

    // control bit on: no flags, pause, then release (R10)
    step(0, 0, 0, 0, 0, 0, 2'b00, 1, 1);
    step(1, 1, D);                                // R4 pause, R7 blocked
    step(1, 0, D, 0, 0, 0, 2'b00, 1, 0);          // still paused, bit cleared
    step(0, 0, D);                                // R6 no tick
    step(1, 0, D);                                // R10 release
    step(1, 1, D);                                // R10 stays running

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule